// File: doc/BRIEF.md
# USB Host Transfer Retry Sequencer

This block runs one host-side USB transaction on an external USB controller that sits behind a byte-wide register port, such as an SPI master. The requester names a transaction kind (SETUP, OUT, IN or handshake) and an endpoint number, then pulses `start`. The sequencer writes the encoded launch value to the controller's launch register. It then checks the status byte returned with that write. If the transfer-complete flag is not yet set there, it keeps reading the controller's interrupt register until the flag appears. After that it reads the result register.

A result code of zero ends the transaction with success. A nonzero code makes the block launch the same transaction again. After `MAX_TRIES` launches that all end in a nonzero code, the block gives up and flags an error. In either case it pulses `done` and reports the last 4-bit code. Filling or draining data FIFOs, setting the device address and managing data toggles are left to other logic.

Top module: `usb_xfer_retry`

## Requirements
- R1: The launch is a write to register 30. The value written holds the endpoint in bits 3:0, sets bit 4 for SETUP (kind 0), sets bit 5 for OUT (kind 1) and sets bit 7 for handshake (kind 3). A handshake also sets bit 5 when `hs_out` is 1. IN (kind 2) sets none of bits 4, 5 and 7. Bit 6 is always 0.
- R2: If bit 7 of the status byte returned with the launch write is set, no interrupt-register read is issued, and the next access is the read of register 31.
- R3: Otherwise the block reads register 25 again and again until a read returns bit 7 set. Exactly one read of register 31 follows.
- R4: If bits 3:0 of the register-31 read are zero, `done` pulses with `result` = 0 and `error` = 0, and no further launch is made.
- R5: A nonzero result code starts a new launch with the identical launch value. At most `MAX_TRIES` launches are made per request.
- R6: When all `MAX_TRIES` launches end in a nonzero code, `done` pulses with `error` = 1 and `result` equal to the last code read.
- R7: `busy` is high from the cycle after an accepted `start` until `done`. A `start` seen while busy is ignored and does not change the launch value.
- R8: After reset `busy`, `done`, `reg_req`, `error` and `result` are all 0. `done` lasts exactly one cycle, and `result`/`error` hold until the next `done`.
- R9: While `reg_req` is high and `reg_ack` is low, `reg_addr`, `reg_wr` and `reg_wdata` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, accepted when idle |
| kind | input | 2 | 0 SETUP, 1 OUT, 2 IN, 3 handshake |
| hs_out | input | 1 | Handshake direction: 1 selects OUT |
| ep | input | 4 | Endpoint number |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 4 | Final result code |
| error | output | 1 | Retry limit reached with nonzero code |
| reg_req | output | 1 | Register access request, held until ack |
| reg_wr | output | 1 | 1 = write, 0 = read |
| reg_addr | output | 5 | Controller register number |
| reg_wdata | output | 8 | Write data |
| reg_ack | input | 1 | Access complete, one cycle |
| reg_rdata | input | 8 | Read data, valid with ack |
| reg_stat | input | 8 | Status byte returned with the command, valid with ack |

## Verification
A wrong state shows up as an access to the wrong register on the very next request after an acknowledge. Examples are a poll issued after an early-done status, or a relaunch after a zero code. The bench's register model counts launches, polls and result reads against arithmetic expectations. A bad retry count or a corrupted launch value appears as a wrong launch count, a wrong `error`/`result` at the `done` pulse, or a write-data mismatch at the next launch.

// File: rtl/usb_xfer_retry.sv
module usb_xfer_retry #(
  parameter int MAX_TRIES  = 4,
  parameter int REG_AW     = 5,
  parameter int LAUNCH_REG = 30,
  parameter int IRQ_REG    = 25,
  parameter int RESULT_REG = 31,
  parameter int DONE_BIT   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        kind,
  input  logic              hs_out,
  input  logic [3:0]        ep,
  output logic              busy,
  output logic              done,
  output logic [3:0]        result,
  output logic              error,
  output logic              reg_req,
  output logic              reg_wr,
  output logic [REG_AW-1:0] reg_addr,
  output logic [7:0]        reg_wdata,
  input  logic              reg_ack,
  input  logic [7:0]        reg_rdata,
  input  logic [7:0]        reg_stat
);

  localparam int TW = $clog2(MAX_TRIES + 1);

  typedef enum logic [1:0] {S_IDLE, S_LAUNCH, S_POLL, S_RESULT} state_t;

  state_t        st;
  logic [7:0]    launch_val;
  logic [TW-1:0] tries;
  logic [7:0]    launch_next;
  logic [3:0]    code;
  logic          last_try;

  assign launch_next = {kind == 2'd3, 1'b0, (kind == 2'd1) || (kind == 2'd3 && hs_out),
                        kind == 2'd0, ep};
  assign code     = reg_rdata[3:0];
  assign last_try = tries == TW'(MAX_TRIES);

  assign busy      = st != S_IDLE;
  assign reg_req   = st != S_IDLE;
  assign reg_wr    = st == S_LAUNCH;
  assign reg_wdata = launch_val;
  assign reg_addr  = (st == S_LAUNCH) ? REG_AW'(LAUNCH_REG) :
                     (st == S_POLL)   ? REG_AW'(IRQ_REG) : REG_AW'(RESULT_REG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      launch_val <= '0;
      tries      <= '0;
      done       <= 1'b0;
      result     <= '0;
      error      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE:
          if (start) begin
            launch_val <= launch_next;
            tries      <= TW'(1);
            st         <= S_LAUNCH;
          end
        S_LAUNCH:
          if (reg_ack) st <= reg_stat[DONE_BIT] ? S_RESULT : S_POLL;
        S_POLL:
          if (reg_ack && reg_rdata[DONE_BIT]) st <= S_RESULT;
        S_RESULT:
          if (reg_ack) begin
            if (code == 4'd0 || last_try) begin
              done   <= 1'b1;
              result <= code;
              error  <= code != 4'd0;
              st     <= S_IDLE;
            end else begin
              tries <= tries + TW'(1);
              st    <= S_LAUNCH;
            end
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && !reg_ack |=> reg_req && $stable(reg_addr) && $stable(reg_wr) && $stable(reg_wdata));
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r4_ok_code_zero: assert property (@(posedge clk) disable iff (!rst_n)
    done && !error |-> result == 4'd0);
  a_r6_err_code_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    done && error |-> result != 4'd0);
  a_r5_tries_cap: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> tries >= TW'(1) && tries <= TW'(MAX_TRIES));
  a_r7_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start |=> busy);
  a_r2_skip_poll: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && reg_wr && reg_ack && reg_stat[DONE_BIT] |=> reg_addr == REG_AW'(RESULT_REG));
  a_r5_relaunch_same: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && reg_wr && !$rose(busy) && !$past(start) |-> $stable(reg_wdata));

endmodule

// File: tb/test_usb_xfer_retry.sv
module test_usb_xfer_retry;
  localparam int MAXT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] kind = 2'd0;
  logic hs_out = 1'b0;
  logic [3:0] ep = 4'd0;
  logic busy, done, error, reg_req, reg_wr;
  logic [3:0] result;
  logic [4:0] reg_addr;
  logic [7:0] reg_wdata;
  logic reg_ack = 1'b0;
  logic [7:0] reg_rdata = 8'd0;
  logic [7:0] reg_stat = 8'd0;

  always #2.5 clk = ~clk;

  usb_xfer_retry #(.MAX_TRIES(MAXT)) i_usb_xfer_retry (
    .clk(clk), .rst_n(rst_n), .start(start), .kind(kind), .hs_out(hs_out), .ep(ep),
    .busy(busy), .done(done), .result(result), .error(error),
    .reg_req(reg_req), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_ack(reg_ack), .reg_rdata(reg_rdata), .reg_stat(reg_stat));

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  int cfg_imm, cfg_npoll, cfg_k, cfg_ep;
  int exp_wdata;
  int n_launch, n_poll, n_res, bad_wdata, bad_addr, poll_left;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int code_of(input int a, input int e);
    return (a + e) % 15 + 1;
  endfunction

  initial begin : responder
    forever begin
      @(negedge clk);
      if (reg_ack) reg_ack = 1'b0;
      else if (reg_req) begin
        reg_stat = 8'h08;
        reg_rdata = 8'h00;
        if (reg_wr && reg_addr == 5'd30) begin
          n_launch++;
          if (int'(reg_wdata) != exp_wdata) bad_wdata++;
          if (cfg_imm != 0) reg_stat = 8'h88;
          poll_left = cfg_npoll;
        end else if (!reg_wr && reg_addr == 5'd25) begin
          n_poll++;
          if (poll_left == 0) reg_rdata = 8'h84;
          else begin reg_rdata = 8'h04; poll_left--; end
        end else if (!reg_wr && reg_addr == 5'd31) begin
          n_res++;
          reg_rdata = 8'hC0 | ((n_launch - 1 < cfg_k) ? 8'(code_of(n_launch - 1, cfg_ep)) : 8'h00);
        end else bad_addr++;
        reg_ack = 1'b1;
      end
    end
  end

  task automatic run(input int kd, input int ho, input int e, input int k, input int np,
                     input int imm, input bit inject);
    int exp_launch, exp_err, exp_res, waited;
    cfg_imm = imm; cfg_npoll = np; cfg_k = k; cfg_ep = e;
    n_launch = 0; n_poll = 0; n_res = 0; bad_wdata = 0; bad_addr = 0;
    exp_wdata = (kd == 3 ? 128 : 0) + ((kd == 1 || (kd == 3 && ho != 0)) ? 32 : 0)
              + (kd == 0 ? 16 : 0) + e;
    exp_launch = (k + 1 < MAXT) ? k + 1 : MAXT;
    exp_err = (k >= MAXT) ? 1 : 0;
    exp_res = exp_err != 0 ? code_of(MAXT - 1, e) : 0;
    @(negedge clk);
    kind = 2'(kd); hs_out = ho[0]; ep = 4'(e); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R7 busy after start", int'(busy), 1);
    if (inject) begin
      @(negedge clk);
      kind = 2'(kd ^ 1); ep = 4'(e ^ 1); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    waited = 0;
    while (!done && waited < 500) begin @(negedge clk); waited++; end
    if (!done) begin
      check(1'b0, "R4 watchdog on done", 0, 1);
      return;
    end
    check(int'(error) == exp_err, "R6 error flag", int'(error), exp_err);
    check(int'(result) == exp_res, "R4 R6 result code", int'(result), exp_res);
    check(n_launch == exp_launch, "R5 launch count", n_launch, exp_launch);
    check(bad_wdata == 0, "R1 launch value", bad_wdata, 0);
    check(bad_addr == 0, "R1 register access kind", bad_addr, 0);
    check(n_res == exp_launch, "R3 result reads", n_res, exp_launch);
    check(n_poll == (imm != 0 ? 0 : exp_launch * (np + 1)), "R2 R3 poll reads",
          n_poll, imm != 0 ? 0 : exp_launch * (np + 1));
    @(negedge clk);
    check(!done && !busy, "R8 done single cycle then idle", int'(done) + int'(busy), 0);
    check(int'(result) == exp_res && int'(error) == exp_err, "R8 result held",
          int'(result), exp_res);
    repeat (3) @(negedge clk);
    check(n_launch == exp_launch, "R4 no launch after done", n_launch, exp_launch);
  endtask

  initial begin : main
    repeat (3) @(negedge clk);
    check(!busy && !done && !reg_req && !error && result == 4'd0, "R8 reset state",
          int'(busy) + int'(done) + int'(reg_req) + int'(error) + int'(result), 0);
    rst_n = 1'b1;
    for (int kd = 0; kd < 4; kd++)
      for (int ho = 0; ho < 2; ho++)
        for (int ei = 0; ei < 3; ei++)
          for (int k = 0; k <= MAXT + 1; k++)
            for (int np = 0; np < 3; np++)
              for (int imm = 0; imm < 2; imm++)
                run(kd, ho, (ei == 0) ? 0 : (ei == 1 ? 5 : 15), k, np, imm,
                    (np >= 1 && imm == 0 && k == 1) ? 1'b1 : 1'b0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R4 global watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule